// File: doc/BRIEF.md
# Split-Speed Two-Source Wakeup Entry

This block is one slot of an out-of-order issue queue, holding a single instruction with two source operands. Each operand has its own readiness path. The operand expected to become available later is stored in a "fast" slot. That slot compares its tag against the result-tag broadcasts in the same cycle they appear. The other operand is stored in a "slow" slot. It compares against a copy of the same broadcasts that an internal pipeline register delays by one clock. As a result, only half of the tag comparators load the critical broadcast wires.

Issue is never speculative. The entry raises a registered request only after both operands are known to be ready. When the slow-side operand is the last one to become ready, the request comes one cycle later than it would in a fully fast design. This happens when both tags are broadcast together, or when the prediction was wrong. There is no flush and no replay in either case.

A grant from select frees the entry, and a new instruction may be written in the same cycle. The entry also reports which of the two sources actually arrived last, so that an external predictor can be trained.

Top module: `swk_wakeup_entry`

## Requirements
- R1: While `rst` is high at a clock edge, `entry_valid` and `issue_req` are 0 after that edge.
- R2: On insert, `ins_pred_last_b`=1 places source B in the fast slot and source A in the slow slot; `ins_pred_last_b`=0 does the opposite.
- R3: If the slow-slot operand is already ready and the fast-slot tag appears on any valid broadcast lane in cycle t, `issue_req` is 1 after the edge that ends cycle t.
- R4: A broadcast of the slow-slot tag in cycle t makes that operand ready only through the delayed bus, so `issue_req` is still 0 after the edge ending cycle t and rises one edge later.
- R5: When both tags are broadcast in the same cycle t, including the insert cycle, `issue_req` rises after the edge ending cycle t+1.
- R6: An operand flagged ready at insert needs no broadcast; with both flagged, `issue_req` is 1 right after the insert edge.
- R7: `issue_req` is 1 only while the entry is valid and both operands are ready; a single wakeup never requests.
- R8: An operand's ready state is kept until the entry is freed; tags on lanes whose valid bit is 0, and tags that match neither operand, have no effect.
- R9: `grant` while `issue_req`=1 frees the entry (`entry_valid`=0 after the edge unless an insert is accepted in that cycle); `grant` while `issue_req`=0 is ignored.
- R10: An insert into a valid entry without a granting `grant` in the same cycle is ignored and the held instruction is unchanged.
- R11: While `issue_req`=1, `last_was_b`=1 means source B's tag was broadcast strictly after source A's; on equal broadcast cycles, or when both were ready at insert, it reports the predicted-last source.
- R12: All `LANES` broadcast lanes wake an operand; lane i carries its tag in `bc_tags[i*TAG_W +: TAG_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Write a new instruction into the entry |
| ins_tag_a | input | TAG_W | Tag of source A |
| ins_tag_b | input | TAG_W | Tag of source B |
| ins_ready_a | input | 1 | Source A already available at insert |
| ins_ready_b | input | 1 | Source B already available at insert |
| ins_pred_last_b | input | 1 | 1: B predicted to arrive last (goes to fast slot) |
| bc_valid | input | LANES | Per-lane broadcast valid |
| bc_tags | input | LANES*TAG_W | Broadcast result tags, lane i at bits i*TAG_W |
| grant | input | 1 | Select grant to this entry |
| entry_valid | output | 1 | Entry holds an instruction |
| issue_req | output | 1 | Both operands ready, request issue |
| last_was_b | output | 1 | Source B arrived last (meaningful with issue_req) |

## Verification
Correct prediction is exercised with both polarities of the selector, so that one wakeup on the fast side is shown to request one edge after the broadcast. A misprediction, where the broadcast hits only the slow slot, must show the request exactly one edge later than that. Both tags broadcast together, in the insert cycle and later, show the single-cycle penalty and the tie rule of the training output. Broadcasts one cycle apart in both orders separate "strictly later" from "equal" arrival. Invalid lanes, stray tags, grants with no request and inserts into a busy entry are each followed by cycles in which the outputs must not move.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int unsigned TAG_W_DEF = 7;
  localparam int unsigned LANES_DEF = 4;

  // which comparator slot an operand occupies
  typedef enum logic {
    SLOT_SLOW = 1'b0,
    SLOT_FAST = 1'b1
  } slot_e;

  // map "last slot" back to the source naming of the instruction
  function automatic logic slot_to_src_b(input slot_e last_slot, input logic fast_is_b);
    return (last_slot == SLOT_FAST) ? fast_is_b : ~fast_is_b;
  endfunction
endpackage

// File: rtl/swk_bus_delay.sv
module swk_bus_delay #(
  parameter int unsigned TAG_W = 7,
  parameter int unsigned LANES = 4,
  localparam int unsigned BUS_W = TAG_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] in_vld,
  input  logic [BUS_W-1:0] in_tags,
  output logic [LANES-1:0] out_vld,
  output logic [BUS_W-1:0] out_tags
);
  logic [LANES-1:0] vld_q;
  logic [BUS_W-1:0] tags_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= in_vld;
  end

  // data path without reset, qualified by the valid bits
  always_ff @(posedge clk) tags_q <= in_tags;

  assign out_vld  = vld_q;
  assign out_tags = tags_q;
endmodule

// File: rtl/swk_tag_match.sv
module swk_tag_match #(
  parameter int unsigned TAG_W = 7,
  parameter int unsigned LANES = 4,
  localparam int unsigned BUS_W = TAG_W * LANES
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [LANES-1:0] bus_vld,
  input  logic [BUS_W-1:0] bus_tags,
  output logic             hit
);
  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = bus_vld[g] && (bus_tags[g*TAG_W +: TAG_W] == tag);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/swk_operand_slot.sv
module swk_operand_slot #(
  parameter int unsigned TAG_W = 7,
  parameter int unsigned LANES = 4,
  localparam int unsigned BUS_W = TAG_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             load_rdy,
  input  logic             clear,
  input  logic [LANES-1:0] bus_vld,
  input  logic [BUS_W-1:0] bus_tags,
  output logic [TAG_W-1:0] tag_q,
  output logic             rdy_q,
  output logic             rdy_next,
  output logic             woke_now
);
  logic [TAG_W-1:0] cmp_tag;
  logic             base_rdy;
  logic             hit;

  // compare the incoming tag during insert so a same-cycle broadcast is caught
  assign cmp_tag  = load ? load_tag : tag_q;
  assign base_rdy = load ? load_rdy : rdy_q;

  swk_tag_match #(.TAG_W(TAG_W), .LANES(LANES)) u_match (
    .tag      (cmp_tag),
    .bus_vld  (bus_vld),
    .bus_tags (bus_tags),
    .hit      (hit)
  );

  assign woke_now = hit && !base_rdy;

  always_comb begin
    if (load)       rdy_next = load_rdy | hit;
    else if (clear) rdy_next = 1'b0;
    else            rdy_next = rdy_q | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= rdy_next;
  end

  always_ff @(posedge clk) begin
    if (load) tag_q <= load_tag;
  end
endmodule

// File: rtl/swk_wakeup_entry.sv
module swk_wakeup_entry
  import swk_pkg::*;
#(
  parameter int unsigned TAG_W = TAG_W_DEF,
  parameter int unsigned LANES = LANES_DEF,
  localparam int unsigned BUS_W = TAG_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [TAG_W-1:0] ins_tag_a,
  input  logic [TAG_W-1:0] ins_tag_b,
  input  logic             ins_ready_a,
  input  logic             ins_ready_b,
  input  logic             ins_pred_last_b,
  input  logic [LANES-1:0] bc_valid,
  input  logic [BUS_W-1:0] bc_tags,
  input  logic             grant,
  output logic             entry_valid,
  output logic             issue_req,
  output logic             last_was_b
);
  logic             valid_q, valid_n;
  logic             req_q;
  logic             fast_is_b_q, fast_is_b_n;
  slot_e            last_slot_q, last_slot_n;
  logic             fast_woke_d;
  logic             lastb_q;
  logic             accept, dealloc;

  logic [LANES-1:0] slow_vld;
  logic [BUS_W-1:0] slow_tags;

  logic [TAG_W-1:0] f_ins_tag, s_ins_tag;
  logic             f_ins_rdy, s_ins_rdy;
  logic [TAG_W-1:0] f_tag_q, s_tag_q;
  logic             f_rdy_q, s_rdy_q, f_rdy_n, s_rdy_n;
  logic             f_woke, s_woke;

  assign dealloc = grant && req_q;
  assign accept  = ins_valid && (!valid_q || dealloc);
  assign valid_n = accept || (valid_q && !dealloc);

  // predicted-last source steers into the fast comparator
  assign f_ins_tag = ins_pred_last_b ? ins_tag_b   : ins_tag_a;
  assign s_ins_tag = ins_pred_last_b ? ins_tag_a   : ins_tag_b;
  assign f_ins_rdy = ins_pred_last_b ? ins_ready_b : ins_ready_a;
  assign s_ins_rdy = ins_pred_last_b ? ins_ready_a : ins_ready_b;

  swk_bus_delay #(.TAG_W(TAG_W), .LANES(LANES)) u_slow_bus (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (bc_valid),
    .in_tags  (bc_tags),
    .out_vld  (slow_vld),
    .out_tags (slow_tags)
  );

  swk_operand_slot #(.TAG_W(TAG_W), .LANES(LANES)) u_fast_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_tag (f_ins_tag),
    .load_rdy (f_ins_rdy),
    .clear    (dealloc),
    .bus_vld  (bc_valid),
    .bus_tags (bc_tags),
    .tag_q    (f_tag_q),
    .rdy_q    (f_rdy_q),
    .rdy_next (f_rdy_n),
    .woke_now (f_woke)
  );

  swk_operand_slot #(.TAG_W(TAG_W), .LANES(LANES)) u_slow_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_tag (s_ins_tag),
    .load_rdy (s_ins_rdy),
    .clear    (dealloc),
    .bus_vld  (slow_vld),
    .bus_tags (slow_tags),
    .tag_q    (s_tag_q),
    .rdy_q    (s_rdy_q),
    .rdy_next (s_rdy_n),
    .woke_now (s_woke)
  );

  // arrival-order tracking: a slow wake one cycle after a fast wake is a tie
  always_comb begin
    fast_is_b_n = accept ? ins_pred_last_b : fast_is_b_q;
    last_slot_n = last_slot_q;
    if (accept)              last_slot_n = SLOT_FAST;
    if (accept || valid_q) begin
      if (f_woke)            last_slot_n = SLOT_FAST;
      else if (s_woke && !accept)
        last_slot_n = fast_woke_d ? SLOT_FAST : SLOT_SLOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      req_q       <= 1'b0;
      fast_is_b_q <= 1'b0;
      last_slot_q <= SLOT_FAST;
      fast_woke_d <= 1'b0;
      lastb_q     <= 1'b0;
    end else begin
      valid_q     <= valid_n;
      req_q       <= valid_n && f_rdy_n && s_rdy_n;
      fast_is_b_q <= fast_is_b_n;
      last_slot_q <= last_slot_n;
      fast_woke_d <= (accept || valid_q) && f_woke;
      lastb_q     <= slot_to_src_b(last_slot_n, fast_is_b_n);
    end
  end

  assign entry_valid = valid_q;
  assign issue_req   = req_q;
  assign last_was_b  = lastb_q;
endmodule

// File: rtl/swk_wakeup_entry_chk.sv
module swk_wakeup_entry_chk #(
  parameter int unsigned TAG_W = 7,
  parameter int unsigned LANES = 4,
  localparam int unsigned BUS_W = TAG_W * LANES
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             grant,
  input logic [LANES-1:0] bc_valid,
  input logic [BUS_W-1:0] bc_tags,
  input logic             entry_valid,
  input logic             issue_req,
  input logic             fast_rdy,
  input logic             slow_rdy,
  input logic [TAG_W-1:0] slow_tag
);
  logic slow_tag_on_fast;
  logic slow_tag_on_fast_d;

  always_comb begin
    slow_tag_on_fast = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (bc_valid[i] && bc_tags[i*TAG_W +: TAG_W] == slow_tag) slow_tag_on_fast = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slow_tag_on_fast_d <= 1'b0;
    else     slow_tag_on_fast_d <= slow_tag_on_fast;
  end

  AST_REQ_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    issue_req |-> entry_valid); // R7

  AST_SLOW_SIDE_LATE: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && !ins_valid && !grant && fast_rdy && !slow_rdy &&
     slow_tag_on_fast && !slow_tag_on_fast_d) |=> !issue_req); // R4

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && fast_rdy && !ins_valid && !grant) |=> fast_rdy); // R8

  AST_GRANT_FREES: assert property (@(posedge clk) disable iff (rst)
    (issue_req && grant && !ins_valid) |=> !entry_valid); // R9

  AST_BUSY_INSERT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && !grant && ins_valid) |=> (entry_valid && $stable(slow_tag))); // R10
endmodule

bind swk_wakeup_entry swk_wakeup_entry_chk #(.TAG_W(TAG_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ins_valid   (ins_valid),
  .grant       (grant),
  .bc_valid    (bc_valid),
  .bc_tags     (bc_tags),
  .entry_valid (entry_valid),
  .issue_req   (issue_req),
  .fast_rdy    (f_rdy_q),
  .slow_rdy    (s_rdy_q),
  .slow_tag    (s_tag_q)
);

// File: tb/test_swk_wakeup_entry.sv
module test_swk_wakeup_entry;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 7;
  localparam int LANES = 4;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   ins_valid = 1'b0;
  logic [TAG_W-1:0]       ins_tag_a = '0;
  logic [TAG_W-1:0]       ins_tag_b = '0;
  logic                   ins_ready_a = 1'b0;
  logic                   ins_ready_b = 1'b0;
  logic                   ins_pred_last_b = 1'b0;
  logic [LANES-1:0]       bc_valid = '0;
  logic [LANES*TAG_W-1:0] bc_tags = '0;
  logic                   grant = 1'b0;
  logic                   entry_valid, issue_req, last_was_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic  ev;
    logic  er;
    int    elb;
    string rq;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swk_wakeup_entry #(.TAG_W(TAG_W), .LANES(LANES)) i_swk_wakeup_entry (
    .clk, .rst, .ins_valid, .ins_tag_a, .ins_tag_b, .ins_ready_a, .ins_ready_b,
    .ins_pred_last_b, .bc_valid, .bc_tags, .grant,
    .entry_valid, .issue_req, .last_was_b
  );

  task automatic cmp(input string rq, input string what, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", rq, what, act, expv, $time);
    end
  endtask

  // monitor: pops one expected item per cycle, after the edge it describes
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.rq, "entry_valid", entry_valid, e.ev);
      cmp(e.rq, "issue_req", issue_req, e.er);
      if (e.elb >= 0) cmp(e.rq, "last_was_b", last_was_b, e.elb[0]);
    end
  end

  task automatic put_ins(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b,
                         input logic ra, input logic rb, input logic pb);
    ins_valid = 1'b1; ins_tag_a = a; ins_tag_b = b;
    ins_ready_a = ra; ins_ready_b = rb; ins_pred_last_b = pb;
  endtask

  task automatic put_bc(input int lane, input logic [TAG_W-1:0] t);
    bc_valid[lane] = 1'b1;
    bc_tags[lane*TAG_W +: TAG_W] = t;
  endtask

  // driver: queue the expectation for this edge, advance, return to idle inputs
  task automatic tick(input logic ev, input logic er, input int elb, input string rq);
    exp_q.push_back('{ev, er, elb, rq});
    @(negedge clk);
    #1;
    ins_valid = 1'b0; grant = 1'b0; bc_valid = '0; bc_tags = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    @(negedge clk); #1;
    tick(0, 0, -1, "R1");
    tick(0, 0, -1, "R1");
    rst = 1'b0;
    tick(0, 0, -1, "R1");

    // R2 R3: B predicted last, A ready at insert, B woken on fast bus
    put_ins(7'd5, 7'd9, 1'b1, 1'b0, 1'b1); tick(1, 0, -1, "R2");
    tick(1, 0, -1, "R7");
    put_bc(0, 7'd9); tick(1, 1, 1, "R3");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R4: misprediction, B sits on the slow side
    put_ins(7'd5, 7'd9, 1'b1, 1'b0, 1'b0); tick(1, 0, -1, "R2");
    put_bc(2, 7'd9); tick(1, 0, -1, "R4");
    tick(1, 1, 1, "R4");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R5 R11: both broadcast together, tie reports predicted (A)
    put_ins(7'd3, 7'd4, 1'b0, 1'b0, 1'b0); tick(1, 0, -1, "R7");
    put_bc(1, 7'd3); put_bc(3, 7'd4); tick(1, 0, -1, "R5");
    tick(1, 1, 0, "R5");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R8 R12: sticky slow ready, invalid lane and stray tag ignored, lane 3 wakes
    put_ins(7'd10, 7'd11, 1'b0, 1'b0, 1'b1); tick(1, 0, -1, "R7");
    put_bc(0, 7'd10); tick(1, 0, -1, "R4");
    tick(1, 0, -1, "R7");
    bc_tags[0 +: TAG_W] = 7'd11; put_bc(1, 7'd12); tick(1, 0, -1, "R8");
    tick(1, 0, -1, "R8");
    put_bc(3, 7'd11); tick(1, 1, 1, "R12");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R6 R10: both ready at insert; busy insert dropped; grant+insert reuses entry
    put_ins(7'd1, 7'd2, 1'b1, 1'b1, 1'b0); tick(1, 1, 0, "R6");
    put_ins(7'd50, 7'd51, 1'b0, 1'b0, 1'b1); tick(1, 1, 0, "R10");
    grant = 1'b1; put_ins(7'd20, 7'd21, 1'b0, 1'b1, 1'b0); tick(1, 0, -1, "R9");
    put_bc(2, 7'd50); tick(1, 0, -1, "R8");
    put_bc(1, 7'd20); tick(1, 1, 0, "R6");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R9 R11: grant without request ignored; B broadcast strictly after A
    put_ins(7'd30, 7'd31, 1'b0, 1'b0, 1'b1); tick(1, 0, -1, "R7");
    grant = 1'b1; tick(1, 0, -1, "R9");
    put_bc(0, 7'd30); tick(1, 0, -1, "R4");
    put_bc(2, 7'd31); tick(1, 1, 1, "R11");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R5 R11: both tags broadcast in the insert cycle
    put_ins(7'd40, 7'd41, 1'b0, 1'b0, 1'b0); put_bc(0, 7'd40); put_bc(1, 7'd41);
    tick(1, 0, -1, "R5");
    tick(1, 1, 0, "R11");
    grant = 1'b1; tick(0, 0, -1, "R9");

    // R11: A broadcast strictly after B (B predicted last, wrong)
    put_ins(7'd60, 7'd61, 1'b0, 1'b0, 1'b1); tick(1, 0, -1, "R7");
    put_bc(3, 7'd61); tick(1, 0, -1, "R7");
    tick(1, 0, -1, "R7");
    put_bc(0, 7'd60); tick(1, 0, -1, "R4");
    tick(1, 1, 0, "R11");
    grant = 1'b1; tick(0, 0, -1, "R9");

    tick(0, 0, -1, "R9");
    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule